// File: doc/BRIEF.md
# Paged Memory Address Translator

This block turns a 16-bit local processor address into a 23-bit global address. Three 8-bit page index registers hold the current page for the program, RAM and EEPROM windows. Each window has a different page size, and the page register supplies the upper bits of the global address for any access that falls inside that window. The rest of the local space maps to the global space in fixed ways. A single control bit moves the 0x4000–0x7FFF region between internal space and external space. The translator also raises a flag when an access must go to the external bus.

Software reads and writes the page registers and the control bit through a small register port. A write takes effect on the clock edge that samples it. Translation is combinational from the address and the registered state, so the global address, the window code and the external flag are valid in the same cycle as the local address.

Top module: `mmap_xlate`

## Requirements
- R1: After reset, reads return the program page 0xFE, the RAM page 0xFD, the EEPROM page 0xFE and a control value of 0x00. Register select codes are 0 for program, 1 for RAM, 2 for EEPROM and 3 for control.
- R2: A write to a register is visible on the read port and in translation only after the clock edge that samples the write strobe. An access in the same cycle as the write uses the old value.
- R3: A local address in 0x8000–0xBFFF maps to global {1'b1, program page, local[13:0]}.
- R4: A program-window access sets the external flag exactly when the program page is below PROG_INT_MIN (default 0xE0).
- R5: A local address in 0xC000–0xFFFF maps to global 0x7F_C000 + local[13:0], with the external flag clear.
- R6: With control bit 0 clear, a local address in 0x4000–0x7FFF maps to global 0x7F_0000 + local, with the external flag clear.
- R7: With control bit 0 set, a local address in 0x4000–0x7FFF maps to global 0x14_0000 + local, with the external flag set.
- R8: A local address in 0x1000–0x1FFF maps to global {3'b000, RAM page, local[11:0]}, with the external flag clear.
- R9: A local address in 0x0800–0x0BFF maps to global {EE_PREFIX (default 5'h04), EEPROM page, local[9:0]}, with the external flag clear.
- R10: Any other local address (0x0000–0x07FF, 0x0C00–0x0FFF, 0x2000–0x3FFF) maps to global 0x7F_0000 + local, with the external flag clear.
- R11: The window code reports 0 for other, 1 for EEPROM, 2 for RAM, 3 for the 0x4000 region, 4 for program paged and 5 for the top fixed region.
- R12: Only bit 0 of a control write is stored. Control reads return zero in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 2 | Register select: 0 program, 1 RAM, 2 EEPROM, 3 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_addr | input | 16 | Local processor address |
| glb_addr | output | 23 | Translated global address |
| ext_acc | output | 1 | Access targets the external bus |
| win_code | output | 3 | Decoded local window |

## Verification
On every cycle, the assertions check the shape of the global address in each window: the fixed top prefix, the program bit and offset, the zero upper bits for RAM, and the EEPROM prefix. They also check that the external flag follows the control bit in the 0x4000 region, and that a write lands one edge later. Only the bench scenarios can show the exact page value placed in each field, and the boundary of the program page threshold. The same holds for the old value used in the cycle of a write, the reset values, and the masking of control bits 7:1. For these the bench compares every output with a model computed separately over random addresses and page values.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int LADDR_W  = 16;
  localparam int GADDR_W  = 23;
  localparam int PAGE_W   = 8;
  localparam int PROG_OFS = 14;
  localparam int RAM_OFS  = 12;
  localparam int EE_OFS   = 10;
  localparam int EE_PFX_W = GADDR_W - PAGE_W - EE_OFS;
  localparam int RAM_PAD  = GADDR_W - PAGE_W - RAM_OFS;
  localparam int FIX_PFX_W = GADDR_W - LADDR_W;

  typedef enum logic [1:0] {
    SEL_PROG = 2'd0,
    SEL_RAM  = 2'd1,
    SEL_EE   = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    WIN_OTHER = 3'd0,
    WIN_EE    = 3'd1,
    WIN_RAM   = 3'd2,
    WIN_LOW   = 3'd3,
    WIN_PROG  = 3'd4,
    WIN_TOP   = 3'd5
  } win_e;
endpackage

// File: rtl/mmap_page_regs.sv
module mmap_page_regs
  import mmap_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PPAGE_RST = 8'hFE,
  parameter logic [PAGE_W-1:0] RPAGE_RST = 8'hFD,
  parameter logic [PAGE_W-1:0] EPAGE_RST = 8'hFE,
  parameter logic              CTRL_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] rdata,
  output logic [PAGE_W-1:0] ppage,
  output logic [PAGE_W-1:0] rpage,
  output logic [PAGE_W-1:0] epage,
  output logic              ctrl
);
  reg_sel_e sel_e;
  logic en_p, en_r, en_e, en_c;
  logic [PAGE_W-1:0] ppage_d, rpage_d, epage_d;
  logic ctrl_d;

  assign sel_e = reg_sel_e'(sel);

  always_comb begin
    en_p = wr && (sel_e == SEL_PROG);
    en_r = wr && (sel_e == SEL_RAM);
    en_e = wr && (sel_e == SEL_EE);
    en_c = wr && (sel_e == SEL_CTRL);
    ppage_d = ppage;
    rpage_d = rpage;
    epage_d = epage;
    ctrl_d  = ctrl;
    if (en_p) ppage_d = wdata;
    if (en_r) rpage_d = wdata;
    if (en_e) epage_d = wdata;
    if (en_c) ctrl_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppage <= PPAGE_RST;
      rpage <= RPAGE_RST;
      epage <= EPAGE_RST;
      ctrl  <= CTRL_RST;
    end else begin
      ppage <= ppage_d;
      rpage <= rpage_d;
      epage <= epage_d;
      ctrl  <= ctrl_d;
    end
  end

  always_comb begin
    unique case (sel_e)
      SEL_PROG: rdata = ppage;
      SEL_RAM:  rdata = rpage;
      SEL_EE:   rdata = epage;
      default:  rdata = {{(PAGE_W-1){1'b0}}, ctrl};
    endcase
  end

  // R2: a write lands one edge later
  assert_prog_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd0) |=> (ppage == $past(wdata)));
  assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd1) |=> (rpage == $past(wdata)));
  // R12: control keeps bit 0 only
  assert_ctrl_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3) |=> (ctrl == $past(wdata[0])));
  assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(epage));
endmodule

// File: rtl/mmap_win_decode.sv
module mmap_win_decode
  import mmap_pkg::*;
(
  input  logic [5:0] addr_hi,
  output win_e       win
);
  always_comb begin
    if (addr_hi[5:4] == 2'b11)        win = WIN_TOP;
    else if (addr_hi[5:4] == 2'b10)   win = WIN_PROG;
    else if (addr_hi[5:4] == 2'b01)   win = WIN_LOW;
    else if (addr_hi[5:2] == 4'h1)    win = WIN_RAM;
    else if (addr_hi == 6'b000010)    win = WIN_EE;
    else                              win = WIN_OTHER;
  end
endmodule

// File: rtl/mmap_addr_gen.sv
module mmap_addr_gen
  import mmap_pkg::*;
#(
  parameter logic [PAGE_W-1:0]   PROG_INT_MIN = 8'hE0,
  parameter logic [EE_PFX_W-1:0] EE_PREFIX    = 5'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  win_e               win,
  input  logic [LADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0]  ppage,
  input  logic [PAGE_W-1:0]  rpage,
  input  logic [PAGE_W-1:0]  epage,
  input  logic               ctrl,
  output logic [GADDR_W-1:0] gaddr,
  output logic               ext
);
  localparam logic [FIX_PFX_W-1:0] INT_PFX = 7'h7F;
  localparam logic [FIX_PFX_W-1:0] EXT_PFX = 7'h14;

  always_comb begin
    gaddr = {INT_PFX, addr};
    ext   = 1'b0;
    unique case (win)
      WIN_EE:   gaddr = {EE_PREFIX, epage, addr[EE_OFS-1:0]};
      WIN_RAM:  gaddr = {{RAM_PAD{1'b0}}, rpage, addr[RAM_OFS-1:0]};
      WIN_LOW: begin
        if (ctrl) begin
          gaddr = {EXT_PFX, addr};
          ext   = 1'b1;
        end
      end
      WIN_PROG: begin
        gaddr = {1'b1, ppage, addr[PROG_OFS-1:0]};
        ext   = (ppage < PROG_INT_MIN);
      end
      default: ;
    endcase
  end

  assert_top_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b11) |-> (gaddr[22:16] == 7'h7F && !ext));
  assert_prog_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b10) |-> (gaddr[22] && gaddr[13:0] == addr[13:0]));
  assert_low_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b01) |-> (ext == ctrl));
  assert_ram_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:12] == 4'h1) |-> (gaddr[22:20] == 3'b000 && !ext));
  assert_ee_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:10] == 6'b000010) |-> (gaddr[22:18] == EE_PREFIX && !ext));
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
  import mmap_pkg::*;
#(
  parameter logic [7:0] PPAGE_RST    = 8'hFE,
  parameter logic [7:0] RPAGE_RST    = 8'hFD,
  parameter logic [7:0] EPAGE_RST    = 8'hFE,
  parameter logic       CTRL_RST     = 1'b0,
  parameter logic [7:0] PROG_INT_MIN = 8'hE0,
  parameter logic [4:0] EE_PREFIX    = 5'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] cpu_addr,
  output logic [22:0] glb_addr,
  output logic        ext_acc,
  output logic [2:0]  win_code
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic [PAGE_W-1:0] ppage, rpage, epage;
  logic ctrl;
  win_e win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mmap_page_regs #(
    .PPAGE_RST(PPAGE_RST), .RPAGE_RST(RPAGE_RST),
    .EPAGE_RST(EPAGE_RST), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .sel(reg_sel), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ppage(ppage), .rpage(rpage), .epage(epage), .ctrl(ctrl)
  );

  mmap_win_decode u_dec (
    .addr_hi(cpu_addr[15:10]), .win(win)
  );

  mmap_addr_gen #(
    .PROG_INT_MIN(PROG_INT_MIN), .EE_PREFIX(EE_PREFIX)
  ) u_gen (
    .clk(clk), .rst_n(rst_int_n), .win(win), .addr(cpu_addr),
    .ppage(ppage), .rpage(rpage), .epage(epage), .ctrl(ctrl),
    .gaddr(glb_addr), .ext(ext_acc)
  );

  assign win_code = win;

  // R11: exactly one class reported, and the code stays in range
  assert_win_range_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_code <= 3'd5);
endmodule

// File: tb/mmap_xlate_test.sv
module mmap_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr;
  logic [22:0] glb_addr;
  logic        ext_acc;
  logic [2:0]  win_code;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_pp, m_rp, m_ep;
  logic       m_c;

  always #10 clk = ~clk;

  mmap_xlate uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .glb_addr(glb_addr), .ext_acc(ext_acc), .win_code(win_code)
  );

  function automatic logic [2:0] ref_win(input logic [15:0] a);
    if (a >= 16'hC000) return 3'd5;
    if (a >= 16'h8000) return 3'd4;
    if (a >= 16'h4000) return 3'd3;
    if (a >= 16'h1000 && a <= 16'h1FFF) return 3'd2;
    if (a >= 16'h0800 && a <= 16'h0BFF) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [22:0] ref_g(input logic [15:0] a);
    case (ref_win(a))
      3'd1: return {5'h04, m_ep, a[9:0]};
      3'd2: return {3'b000, m_rp, a[11:0]};
      3'd3: return m_c ? (23'h14_0000 + 23'(a)) : (23'h7F_0000 + 23'(a));
      3'd4: return {1'b1, m_pp, a[13:0]};
      default: return 23'h7F_0000 + 23'(a);
    endcase
  endfunction

  function automatic logic ref_ext(input logic [15:0] a);
    if (ref_win(a) == 3'd4) return m_pp < 8'hE0;
    if (ref_win(a) == 3'd3) return m_c;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [15:0] a);
    case (ref_win(a))
      3'd1: return "R9";
      3'd2: return "R8";
      3'd3: return m_c ? "R7" : "R6";
      3'd4: return "R3/R4";
      3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [15:0] a);
    cpu_addr = a;
    #1;
    chk(req_of(a), 32'(glb_addr), 32'(ref_g(a)));
    chk(req_of(a), 32'(ext_acc), 32'(ref_ext(a)));
    chk("R11", 32'(win_code), 32'(ref_win(a)));
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string req);
    reg_sel = s;
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (s)
      2'd0: m_pp = d;
      2'd1: m_rp = d;
      2'd2: m_ep = d;
      default: m_c = d[0];
    endcase
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00; cpu_addr = 16'h0000;
    m_pp = 8'hFE; m_rp = 8'hFD; m_ep = 8'hFE; m_c = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd(2'd0, 8'hFE, "R1");
    rd(2'd1, 8'hFD, "R1");
    rd(2'd2, 8'hFE, "R1");
    rd(2'd3, 8'h00, "R1");

    // directed corners: every window edge
    probe(16'h0000); probe(16'h07FF); probe(16'h0800); probe(16'h0BFF);
    probe(16'h0C00); probe(16'h0FFF); probe(16'h1000); probe(16'h1FFF);
    probe(16'h2000); probe(16'h3FFF); probe(16'h4000); probe(16'h7FFF);
    probe(16'h8000); probe(16'hBFFF); probe(16'hC000); probe(16'hFFFF);

    // R2 same-cycle write uses old page, new page after the edge
    @(negedge clk);
    cpu_addr = 16'h8123; reg_sel = 2'd0; reg_wdata = 8'h3C; reg_wr = 1'b1;
    #1;
    chk("R2", 32'(glb_addr), 32'({1'b1, 8'hFE, 14'h0123}));
    chk("R2", 32'(reg_rdata), 32'h0000_00FE);
    @(negedge clk);
    reg_wr = 1'b0; m_pp = 8'h3C;
    #1;
    chk("R2", 32'(glb_addr), 32'({1'b1, 8'h3C, 14'h0123}));
    chk("R4", 32'(ext_acc), 32'd1);

    // R4 threshold edges
    wr_reg(2'd0, 8'hDF); probe(16'h9ABC);
    wr_reg(2'd0, 8'hE0); probe(16'h9ABC);

    // R12 control masking, then R7 region
    wr_reg(2'd3, 8'hFF);
    rd(2'd3, 8'h01, "R12");
    probe(16'h4000); probe(16'h7FFF);
    wr_reg(2'd3, 8'hFE);
    rd(2'd3, 8'h00, "R12");
    probe(16'h5555);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 3));
        wr_reg(s, 8'($urandom));
        rd(s, s == 2'd3 ? {7'b0, m_c} :
              s == 2'd0 ? m_pp : s == 2'd1 ? m_rp : m_ep, "R2");
      end
      @(negedge clk);
      probe(16'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule